// File: doc/BRIEF.md
# Masked Trigger Combiner and Event Gate Sequencer

This block takes a bank of raw trigger lines and an enable mask set over a small register port. It forms a "grand OR" of the enabled lines. A separate pair of event-trigger inputs is ORed into one event request. When no event is in progress, a rising edge of that request starts a fixed sequence:

- a one-cycle trigger pulse;
- a digitizer start pulse after a programmable delay;
- a converter gate of programmable width;
- a busy flag that holds off further events.

Busy stays up until the readout logic signals completion with a done strobe, and never drops before the gate and the start pulse have finished. At the moment of acceptance the block also latches which enabled trigger lines were active, so readout can tell which source caused the event.

All inputs are treated as asynchronous and pass through a two-flop synchronizer. The event request is edge-detected, so a long pulse counts once. The block has no streaming data path: every pin is a plain control or status level, and the register port completes a write in one cycle with no back-pressure.

Top module: `trig_gate_seq`

## Requirements
- R1: `grand_or` is high exactly when some synchronized trigger line is high and its mask bit is set (bit i enables `trig_in[i]`). A change on `trig_in` reaches `grand_or` after two clock edges, and a mask write takes effect at its write edge.
- R2: Register map on `reg_addr`:
  - 0: enable mask, reset value all ones.
  - 1: start delay, reset value 0.
  - 2: gate width, reset value 0.
  - 3: source latch, read-only.

  Writes to 0 to 2 read back unchanged through `reg_rdata`, which is combinational. Writes to 3 are ignored.
- R3: A rising edge of (`evt_a` OR `evt_b`), held for at least one cycle, produces `trig_pulse` high for exactly one cycle. That cycle begins at the third clock edge after the input rises. Overlapping pulses on both inputs give a single trigger.
- R4: An event request whose edge arrives while `busy` is high produces no trigger, start or gate output.
- R5: `start_pulse` is high for one cycle, exactly D cycles after the `trig_pulse` cycle. D is the delay register, or 1 when the register holds 0.
- R6: `conv_gate` rises in the `trig_pulse` cycle and stays high for exactly W cycles. W is the width register, or 1 when the register holds 0.
- R7: `busy` rises in the `trig_pulse` cycle. Let the sequence end at cycle max(W, D+1) after the trigger. A done strobe seen before that end is remembered, and `busy` then falls one cycle after the end. A later done strobe makes `busy` fall on the next cycle. A done strobe while not busy has no effect.
- R8: Register 3 returns the masked trigger vector captured on the accepting edge and holds it while busy. It reads zero once busy has cleared.
- R9: After reset, `trig_pulse`, `start_pulse`, `conv_gate` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_CH | Raw trigger lines |
| evt_a | input | 1 | Event-trigger request, first source |
| evt_b | input | 1 | Event-trigger request, second source |
| readout_done | input | 1 | Strobe: readout of current event finished |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| grand_or | output | 1 | OR of enabled, synchronized trigger lines |
| trig_pulse | output | 1 | One-cycle accepted-event pulse |
| start_pulse | output | 1 | Delayed digitizer start pulse |
| conv_gate | output | 1 | Converter gate of programmed width |
| busy | output | 1 | Event in progress |

## Verification
The grand OR is swept over all 256 masks against a walking-one pattern, the all-zero pattern and the all-ones pattern. Sampling one edge and then two edges after each change separates a wrong mask bit from a wrong synchronizer depth. The sequencer runs every delay and width combination from 0 to 6, plus one long delay. Each of these is checked at every cycle, which separates the zero-as-one rule, off-by-one counts and the end of busy. The event source is rotated through evt_a alone, evt_b alone and an overlap of both, to distinguish OR-then-edge from per-input edges. Done strobes arrive early, late and while idle, and an extra request is injected during a long event to show the veto.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
  typedef enum logic [1:0] {
    ADDR_MASK  = 2'd0,
    ADDR_DELAY = 2'd1,
    ADDR_WIDTH = 2'd2,
    ADDR_SRC   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tgs_sync2.sv
// Two-flop synchronizer, one chain per bit.
module tgs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/tgs_event_seq.sv
// Edge-detects the event request, vetoes it while busy, and runs the
// start-delay and gate-width counters plus the busy/done handshake.
module tgs_event_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_lvl,
  input  logic             readout_done,
  input  logic [CNT_W-1:0] dly_cfg,
  input  logic [CNT_W-1:0] wid_cfg,
  output logic             accept,
  output logic             busy_clr,
  output logic             trig_pulse,
  output logic             start_pulse,
  output logic             conv_gate,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             evt_prev;
  logic [CNT_W-1:0] dcnt, gcnt;
  logic [CNT_W-1:0] d_eff, w_eff;
  logic             pend;
  logic             idle;

  assign d_eff    = (dly_cfg == '0) ? ONE : dly_cfg;
  assign w_eff    = (wid_cfg == '0) ? ONE : wid_cfg;
  assign accept   = evt_lvl & ~evt_prev & ~busy;
  assign idle     = (dcnt == '0) && (gcnt == '0) && !start_pulse;
  assign busy_clr = busy && idle && (readout_done || pend);
  assign conv_gate = (gcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev    <= 1'b0;
      trig_pulse  <= 1'b0;
      start_pulse <= 1'b0;
      dcnt        <= '0;
      gcnt        <= '0;
      busy        <= 1'b0;
      pend        <= 1'b0;
    end else begin
      evt_prev    <= evt_lvl;
      trig_pulse  <= accept;
      start_pulse <= (dcnt == ONE);

      if (accept)            dcnt <= d_eff;
      else if (dcnt != '0)   dcnt <= dcnt - ONE;

      if (accept)            gcnt <= w_eff;
      else if (gcnt != '0)   gcnt <= gcnt - ONE;

      if (accept)            busy <= 1'b1;
      else if (busy_clr)     busy <= 1'b0;

      if (busy_clr)                            pend <= 1'b0;
      else if (busy && readout_done && !idle)  pend <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_gate_seq.sv
module trig_gate_seq
  import trig_gate_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   trig_in,
  input  logic              evt_a,
  input  logic              evt_b,
  input  logic              readout_done,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              grand_or,
  output logic              trig_pulse,
  output logic              start_pulse,
  output logic              conv_gate,
  output logic              busy
);
  logic [N_CH-1:0]  trig_lvl;
  logic [1:0]       evt_sync;
  logic [N_CH-1:0]  mask_q;
  logic [CNT_W-1:0] dly_q, wid_q;
  logic [N_CH-1:0]  src_q;
  logic             accept, busy_clr;

  tgs_sync2 #(.W(N_CH)) u_sync_trig (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_lvl)
  );

  tgs_sync2 #(.W(2)) u_sync_evt (
    .clk(clk), .rst_n(rst_n), .d({evt_b, evt_a}), .q(evt_sync)
  );

  tgs_event_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .evt_lvl(|evt_sync), .readout_done(readout_done),
    .dly_cfg(dly_q), .wid_cfg(wid_q),
    .accept(accept), .busy_clr(busy_clr),
    .trig_pulse(trig_pulse), .start_pulse(start_pulse),
    .conv_gate(conv_gate), .busy(busy)
  );

  assign grand_or = |(trig_lvl & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      dly_q  <= '0;
      wid_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr_e'(reg_addr))
        ADDR_MASK:  mask_q <= reg_wdata[N_CH-1:0];
        ADDR_DELAY: dly_q  <= reg_wdata[CNT_W-1:0];
        ADDR_WIDTH: wid_q  <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        src_q <= '0;
    else if (accept)   src_q <= trig_lvl & mask_q;
    else if (busy_clr) src_q <= '0;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      ADDR_MASK:  reg_rdata = DATA_W'(mask_q);
      ADDR_DELAY: reg_rdata = DATA_W'(dly_q);
      ADDR_WIDTH: reg_rdata = DATA_W'(wid_q);
      default:    reg_rdata = DATA_W'(src_q);
    endcase
  end
endmodule

// File: rtl/trig_gate_seq_chk.sv
module trig_gate_seq_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_pulse,
  input logic            start_pulse,
  input logic            conv_gate,
  input logic            busy,
  input logic            grand_or,
  input logic [N_CH-1:0] mask
);
  a_r4_no_trig_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !$past(busy));
  a_r3_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  a_r7_busy_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> busy);
  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r5_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);
  a_r6_gate_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_gate |-> busy);
  a_r7_busy_fall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!conv_gate && !start_pulse && $past(!conv_gate)));
  a_r1_gor_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    grand_or |-> (mask != '0));
endmodule

bind trig_gate_seq trig_gate_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_pulse(trig_pulse),
  .start_pulse(start_pulse), .conv_gate(conv_gate), .busy(busy),
  .grand_or(grand_or), .mask(mask_q)
);

// File: tb/test_trig_gate_seq.sv
module test_trig_gate_seq;
  localparam int N_CH = 8, CNT_W = 8, DATA_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   trig_in = '0;
  logic              evt_a = 1'b0, evt_b = 1'b0, readout_done = 1'b0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic grand_or, trig_pulse, start_pulse, conv_gate, busy;

  int n_vec = 0, n_bad = 0;

  trig_gate_seq #(.N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_trig_gate_seq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .evt_a(evt_a), .evt_b(evt_b),
    .readout_done(readout_done), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grand_or(grand_or),
    .trig_pulse(trig_pulse), .start_pulse(start_pulse),
    .conv_gate(conv_gate), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // mode 0: evt_a only, 1: evt_b only, 2: overlapping a then b
  task automatic run_event(input int d, input int w, input logic [7:0] pat,
                           input logic [7:0] m, input int mode,
                           input bit late_done, input bit veto);
    int de, we, lend, done_at, bend, last;
    logic [7:0] v;
    de = (d == 0) ? 1 : d;
    we = (w == 0) ? 1 : w;
    lend = (we > de + 1) ? we : de + 1;
    done_at = late_done ? lend + 2 : 0;
    bend = late_done ? lend + 2 : lend;
    last = bend + 3;
    wr(2'd0, m); wr(2'd1, 8'(d)); wr(2'd2, 8'(w));
    trig_in = pat;
    repeat (3) @(negedge clk);
    if (mode == 1) evt_b = 1'b1; else evt_a = 1'b1;
    @(negedge clk);
    chk("R3 trig before latency", trig_pulse, 0);
    if (mode == 0) evt_a = 1'b0;
    if (mode == 1) evt_b = 1'b0;
    if (mode == 2) evt_b = 1'b1;
    @(negedge clk);
    chk("R3 trig before latency", trig_pulse, 0);
    if (mode == 2) evt_a = 1'b0;
    @(negedge clk);
    for (int off = 0; off <= last; off++) begin
      chk("R3 trig pulse", trig_pulse, (off == 0));
      chk("R5 start pulse", start_pulse, (off == de));
      chk("R6 conv gate", conv_gate, (off < we));
      chk("R7 busy", busy, (off <= bend));
      if (off == 0) begin
        if (mode == 2) evt_b = 1'b0;
        rd(2'd3, v);
        chk("R8 source latch", v, pat & m);
      end
      readout_done = (off == done_at);
      if (veto && off == 2) evt_b = 1'b1;
      if (veto && off == 3) evt_b = 1'b0;
      @(negedge clk);
    end
    readout_done = 1'b0;
    rd(2'd3, v);
    chk("R8 source cleared", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, p, pold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 trig reset", trig_pulse, 0);
    chk("R9 start reset", start_pulse, 0);
    chk("R9 gate reset", conv_gate, 0);
    chk("R9 busy reset", busy, 0);
    // R2 reset values and map
    rd(2'd0, v); chk("R2 mask reset", v, 8'hFF);
    rd(2'd1, v); chk("R2 delay reset", v, 0);
    rd(2'd2, v); chk("R2 width reset", v, 0);
    rd(2'd3, v); chk("R2 source reset", v, 0);
    wr(2'd1, 8'h3C); rd(2'd1, v); chk("R2 delay readback", v, 8'h3C);
    wr(2'd2, 8'hA5); rd(2'd2, v); chk("R2 width readback", v, 8'hA5);
    wr(2'd0, 8'h96); rd(2'd0, v); chk("R2 mask readback", v, 8'h96);
    wr(2'd3, 8'h5A); rd(2'd3, v); chk("R2 source write ignored", v, 0);

    // R1 full mask sweep with synchronizer latency
    pold = trig_in;
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 8'(m));
      for (int i = -1; i <= 8; i++) begin
        p = (i < 0) ? 8'h00 : ((i == 8) ? 8'hFF : 8'(1 << i));
        trig_in = p;
        @(negedge clk);
        chk("R1 grand or one edge", grand_or, |(pold & 8'(m)));
        @(negedge clk);
        chk("R1 grand or two edges", grand_or, |(p & 8'(m)));
        pold = p;
      end
    end

    // R5 R6 R7 R8 sweep of delay and width, sources rotated (R3)
    for (int d = 0; d <= 6; d++)
      for (int w = 0; w <= 6; w++)
        run_event(d, w, 8'(1 << d) | (8'h80 >> w), 8'hFF ^ 8'(1 << ((d + w) % 8)),
                  (d + w) % 3, 1'b0, 1'b0);

    // long delay, late done (R5, R7)
    run_event(200, 3, 8'hC3, 8'h0F, 0, 1'b1, 1'b0);
    run_event(2, 9, 8'h5A, 8'hFF, 2, 1'b1, 1'b0);

    // R4 veto: extra request during a long event
    run_event(10, 10, 8'h81, 8'hFF, 0, 1'b0, 1'b1);

    // R7 done while idle is ignored
    readout_done = 1'b1;
    @(negedge clk);
    readout_done = 1'b0;
    chk("R7 idle done no busy", busy, 0);
    @(negedge clk);
    chk("R7 idle done no trig", trig_pulse, 0);
    run_event(3, 4, 8'h24, 8'h3C, 1, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule